// File: doc/BRIEF.md
# Programmable Interval Timer with Divider

This block is a memory-mapped interval timer. It contains a free-running 16-bit divider and an 8-bit counter that reloads from a modulo register, and it raises a one-clock interrupt request on each overflow. It runs from a system clock of about 4.19 MHz. The divider advances on every clock. The counter advances on each falling edge of one of four divider bits, and the control register picks which bit. With the nominal clock this gives counter rates of 4096, 262144, 65536 or 16384 Hz.

Software uses a byte-wide register bus with a two-bit address:

| Address | Register |
|---------|----------|
| 0 | divider |
| 1 | counter |
| 2 | modulo |
| 3 | control |

Reads are combinational on the address. A write takes effect at the clock edge on which the write strobe is high. An external interrupt controller latches the interrupt pulse.

Top module: `interval_timer`

## Requirements
- R1: The 16-bit divider increments on every clock. A read of address 0 returns its upper 8 bits.
- R2: A write of any data to address 0 clears all 16 bits of the divider to zero.
- R3: While control bit 2 is set, the counter (address 1) increments once for each falling edge of the selected divider bit. Control bits 1:0 select the bit:
  - 00 selects bit 9.
  - 01 selects bit 3.
  - 10 selects bit 5.
  - 11 selects bit 7.
- R4: An increment from 0xFF loads the counter with the modulo register value held before that clock edge.
- R5: While control bit 2 is clear, the counter holds its value unless it is written.
- R6: The interrupt request goes high for exactly one clock. It is high in the cycle after the reload edge, which is the first cycle in which the counter shows the reloaded value. It is low at all other times.
- R7: The counter, modulo and control registers can be read and written. Control reads back as {5'b11111, bits 2:0}.
- R8: A counter write in the same cycle as an increment wins. The counter takes the written value and no interrupt is issued.
- R9: If a divider clear makes the selected bit fall from 1 to 0 while counting is enabled, the counter increments, exactly as for a natural falling edge.
- R10: After a synchronous active-low reset:
  - The divider, counter and modulo registers are 0.
  - Control reads 0xF8.
  - The interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | One-clock timer interrupt request |

## Verification
The embedded assertions check these rules on every cycle:
- the divider steps by one or clears;
- the counter steps by one on a tick;
- an overflow loads the previous modulo value and raises the pulse;
- a bus write wins over a same-cycle tick;
- the counter stays stable while disabled;
- the interrupt never lasts two cycles.

Only the bench scenarios can show the rest, because these depend on the history of the divider over many cycles:
- each of the four rate selections counts at the right interval;
- a divider clear in the middle of a period produces an extra tick;
- the read-back formats are correct.

// File: rtl/itmr_pkg.sv
// Package: shared register address encoding for the interval timer.
// Assumes a two-bit register address on the byte bus.
package itmr_pkg;
    typedef enum logic [1:0] {
        REG_DIV    = 2'd0,
        REG_COUNT  = 2'd1,
        REG_MODULO = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    localparam int unsigned CTRL_BITS = 3;
endpackage

// File: rtl/itmr_divider.sv
// Free-running divider counter.
// Increments on every clock. A clear request zeroes every bit.
// Assumes clear is a single-cycle strobe decoded from a bus write.
module itmr_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [DIV_W-1:0] div
);
    // Step the divider or clear it on request.
    always_ff @(posedge clk) begin
        if (!rst_n)     div <= '0;
        else if (clear) div <= '0;
        else            div <= div + 1'b1;
    end

    a_r1_div_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> div == $past(div) + 1'b1);
    a_r2_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> div == '0);
endmodule

// File: rtl/itmr_tap_edge.sv
// Falling-edge detector on the selected divider tap.
// Keeps the previous value of each of the four candidate tap bits.
// Raises tick for one cycle when the selected bit went from 1 to 0 since
// the last clock and counting is enabled.
// Assumes tap positions lie inside the divider width.
module itmr_tap_edge #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned TAP0  = 9,
    parameter int unsigned TAP1  = 3,
    parameter int unsigned TAP2  = 5,
    parameter int unsigned TAP3  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic [1:0]       sel,
    input  logic             enable,
    output logic             tick
);
    localparam int unsigned NTAPS = 4;
    localparam int unsigned TAPS [NTAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [NTAPS-1:0] cur_bits;
    logic [NTAPS-1:0] prev_bits;

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        assign cur_bits[i] = div[TAPS[i]];

        // Remember this tap bit for the next cycle's edge compare.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_bits[i] <= 1'b0;
            else        prev_bits[i] <= cur_bits[i];
        end
    end

    // Detect a falling edge on the selected tap, gated by enable.
    always_comb begin
        tick = enable & prev_bits[sel] & ~cur_bits[sel];
    end
endmodule

// File: rtl/itmr_counter.sv
// Reloadable counter with an overflow interrupt pulse.
// A bus load wins over a tick. A tick at all-ones loads the modulo value
// and registers a one-cycle irq that appears together with the reload.
// Assumes ticks are at least two cycles apart.
module itmr_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Update the count: bus load, overflow reload or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else if (load) begin
            count <= load_val;
            irq   <= 1'b0;
        end else if (tick && count == CNT_MAX) begin
            count <= modulo;
            irq   <= 1'b1;
        end else begin
            if (tick) count <= count + 1'b1;
            irq <= 1'b0;
        end
    end

    a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && count != CNT_MAX |=> count == $past(count) + 1'b1);
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && count == CNT_MAX |=> count == $past(modulo) && irq);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val) && !irq);
endmodule

// File: rtl/interval_timer.sv
// Top level of the interval timer.
// Decodes the byte bus, holds the modulo and control registers, and ties
// together the divider, the tap edge detector and the counter.
// Assumes reads are combinational and writes take effect at the clock edge.
module interval_timer #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TAP0   = 9,
    parameter int unsigned TAP1   = 3,
    parameter int unsigned TAP2   = 5,
    parameter int unsigned TAP3   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import itmr_pkg::*;

    localparam int unsigned CW = CTRL_BITS;

    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] modulo_q;
    logic [CW-1:0]     ctrl_q;
    logic              tick;
    logic              wr_div;
    logic              wr_count;
    logic              wr_mod;
    logic              wr_ctrl;
    reg_sel_e          sel;

    // Decode bus writes per register.
    always_comb begin
        sel      = reg_sel_e'(bus_addr);
        wr_div   = bus_wr && sel == REG_DIV;
        wr_count = bus_wr && sel == REG_COUNT;
        wr_mod   = bus_wr && sel == REG_MODULO;
        wr_ctrl  = bus_wr && sel == REG_CTRL;
    end

    // Hold the modulo and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modulo_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (wr_mod)  modulo_q <= bus_wdata;
            if (wr_ctrl) ctrl_q   <= bus_wdata[CW-1:0];
        end
    end

    // Select read data for the addressed register.
    always_comb begin
        unique case (sel)
            REG_DIV:    bus_rdata = div[DIV_W-1 -: DATA_W];
            REG_COUNT:  bus_rdata = count;
            REG_MODULO: bus_rdata = modulo_q;
            default:    bus_rdata = {{(DATA_W-CW){1'b1}}, ctrl_q};
        endcase
    end

    itmr_divider #(.DIV_W(DIV_W)) u_divider (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (wr_div),
        .div   (div)
    );

    itmr_tap_edge #(
        .DIV_W(DIV_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_tap_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .div    (div),
        .sel    (ctrl_q[1:0]),
        .enable (ctrl_q[2]),
        .tick   (tick)
    );

    itmr_counter #(.CNT_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_count),
        .load_val (bus_wdata),
        .modulo   (modulo_q),
        .count    (count),
        .irq      (irq)
    );

    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[2] && !wr_count |=> $stable(count));
    a_r10_ctrl_pad: assert property (@(posedge clk) disable iff (!rst_n)
        sel == REG_CTRL |-> bus_rdata[DATA_W-1:CW] == '1);
endmodule

// File: tb/interval_timer_bench.sv
// Self-checking bench: a cycle model built from the requirements, directed
// corner cases and seeded random bus traffic.
module interval_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state.
    logic [15:0] m_div, m_prev;
    logic [7:0]  m_cnt, m_mod;
    logic [2:0]  m_ctrl;
    logic        m_irq;

    always #10 clk = ~clk;

    interval_timer u_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int m_tap(input logic [1:0] s);
        case (s)
            2'd0: return 9;
            2'd1: return 3;
            2'd2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic logic m_tick();
        int t = m_tap(m_ctrl[1:0]);
        return m_ctrl[2] && m_prev[t] && !m_div[t];
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_div[15:8];
            2'd1: return m_cnt;
            2'd2: return m_mod;
            default: return {5'b11111, m_ctrl};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, input string tag);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, m_read(a));
        chk("R6", {7'd0, irq}, {7'd0, m_irq});
    endtask

    // One clock with the given bus inputs; the model advances in step.
    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d);
        logic        tk = m_tick();
        logic [15:0] n_div = (w && a == 2'd0) ? 16'd0 : m_div + 16'd1;
        logic [7:0]  n_cnt = m_cnt;
        logic        n_irq = 1'b0;
        bus_wr = w;
        bus_addr = a;
        bus_wdata = d;
        if (w && a == 2'd1) n_cnt = d;
        else if (tk && m_cnt == 8'hFF) begin
            n_cnt = m_mod;
            n_irq = 1'b1;
        end else if (tk) n_cnt = m_cnt + 8'd1;
        @(posedge clk);
        m_prev = m_div;
        m_div = n_div;
        m_cnt = n_cnt;
        m_irq = n_irq;
        if (w && a == 2'd2) m_mod = d;
        if (w && a == 2'd3) m_ctrl = d[2:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_div = '0; m_prev = '0; m_cnt = '0; m_mod = '0; m_ctrl = '0; m_irq = 1'b0;

        // R10: reset state, read before the first active edge.
        for (int a = 0; a < 4; a++) peek(a[1:0], "R10");

        // R1: the divider's upper byte advances after 256 clocks.
        idle(600);
        peek(2'd0, "R1");

        // R2: a write clears the divider.
        cyc(1'b1, 2'd0, 8'h5A);
        peek(2'd0, "R2");
        idle(300);
        peek(2'd0, "R2");

        // R7: register read/write with control padding.
        cyc(1'b1, 2'd2, 8'hC3); peek(2'd2, "R7");
        cyc(1'b1, 2'd3, 8'hF2); peek(2'd3, "R7");
        cyc(1'b1, 2'd1, 8'h11); peek(2'd1, "R7");

        // R3: each rate selection counts at its tap rate.
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 2'd1, 8'h00);
            cyc(1'b1, 2'd3, {5'd0, 1'b1, s[1:0]});
            idle(3000);
            peek(2'd1, "R3");
        end

        // R4/R6: overflow reload and interrupt pulse at the fastest rate.
        cyc(1'b1, 2'd2, 8'hA0);
        cyc(1'b1, 2'd3, 8'h05);
        cyc(1'b1, 2'd1, 8'hFE);
        for (int i = 0; i < 100; i++) begin
            cyc(1'b0, 2'd1, 8'd0);
            peek(2'd1, m_irq ? "R4" : "R3");
        end

        // R5: counting disabled holds the counter.
        cyc(1'b1, 2'd3, 8'h01);
        idle(200);
        peek(2'd1, "R5");

        // R8: a write in the same cycle as an overflow tick wins.
        cyc(1'b1, 2'd1, 8'hFF);
        cyc(1'b1, 2'd3, 8'h05);
        while (!m_tick()) cyc(1'b0, 2'd1, 8'd0);
        cyc(1'b1, 2'd1, 8'h33);
        peek(2'd1, "R8");
        chk("R8", {7'd0, irq}, 8'd0);

        // R9: clearing the divider while the bit-9 tap is high gives a tick.
        cyc(1'b1, 2'd3, 8'h04);
        cyc(1'b1, 2'd1, 8'h40);
        while (!m_div[9]) cyc(1'b0, 2'd1, 8'd0);
        idle(2);
        cyc(1'b1, 2'd0, 8'h00);
        cyc(1'b0, 2'd1, 8'd0);
        peek(2'd1, "R9");
        chk("R9", m_cnt, 8'h41);

        // Random bus traffic against the model.
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] ra = 2'($urandom_range(0, 3));
            string tg = ra == 2'd0 ? "R1" : ra == 2'd1 ? "R3" : "R7";
            peek(ra, tg);
            if ($urandom_range(0, 15) == 0)
                cyc(1'b1, 2'($urandom_range(0, 3)), 8'($urandom));
            else
                cyc(1'b0, ra, 8'd0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule